// File: doc/BRIEF.md
# Serial Access Register Port

This block is the serial side of a video memory. It holds one row of 512 bytes and a 9-bit address pointer. A host can move a whole row into the register through a single-cycle transfer strobe, or take the row out of it through the same strobe. Each transfer also loads the pointer with a start column. After the transfer, a slow serial clock walks the pointer through the row, one entry per rising edge. Each edge either presents a byte on the serial output or stores the byte on the serial input.

The direction of the serial port depends on the most recent transfer. A row-to-register transfer puts the port into output mode. A register-to-row transfer puts it into input mode. An active-low serial enable does two things: it gates the output drive, and it masks stores. The pointer still advances on every serial clock edge, so holding the enable inactive for some edges skips those entries.

The serial clock `sc` is sampled in the system clock domain. A rising edge is seen as `sc` high in a cycle where it was low at the previous edge. The bidirectional serial pins are split into input, output and output-enable signals. The pad is expected to drive the pins with `sio_out` while `sio_oe` is high.

Top module: `sam_port`

## Requirements
- R1: While reset is low and after it is released, `sio_oe` is 0, `sio_out` is 0 and every register entry reads as 0 on `row_out`.
- R2: A cycle with `xfer_valid`=1 and `xfer_to_sam`=1 copies `row_in` into all entries. Entry i lives in bits [8i+7:8i] of `row_in` and `row_out`. The new contents show on `row_out` after that clock edge.
- R3: Any transfer loads the pointer with `xfer_col`. In output mode, the first serial rising edge after a transfer presents entry `xfer_col` on `sio_out`. Each further rising edge presents the next entry.
- R4: `sio_out` changes only at the clock edge that detects a serial rising edge, which is the first system clock edge at which `sc` is seen high after being low. It holds its value at every other edge.
- R5: `sio_oe` is 1 exactly when the port is in output mode and `se_n` is 0.
- R6: A cycle with `xfer_valid`=1 and `xfer_to_sam`=0 selects input mode, so `sio_oe` is 0 whatever the level of `se_n`. It leaves all entries unchanged.
- R7: In input mode, a serial rising edge with `se_n`=0 stores `sio_in` into the entry at the pointer, then advances the pointer.
- R8: A serial rising edge with `se_n`=1 stores nothing, but the pointer still advances. The next unmasked store therefore lands one entry further on.
- R9: The pointer wraps from entry 511 to entry 0.
- R10: When a transfer and a serial rising edge fall in the same cycle, the transfer takes effect and the serial edge is dropped. The pointer holds `xfer_col`, nothing is stored, and `sio_out` keeps its value.
- R11: In output mode, serial edges never alter the stored entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sc | input | 1 | Serial clock level; each rising edge is one serial step |
| se_n | input | 1 | Active-low serial enable: gates output drive and masks stores |
| sio_in | input | 8 | Serial data arriving from the pins |
| sio_out | output | 8 | Serial data to drive onto the pins |
| sio_oe | output | 1 | Pin drive enable for `sio_out` |
| xfer_valid | input | 1 | One-cycle transfer strobe |
| xfer_to_sam | input | 1 | 1: row into register (output mode); 0: register out to row (input mode) |
| xfer_col | input | 9 | Pointer start column loaded by a transfer |
| row_in | input | 4096 | Row data loaded by a row-to-register transfer |
| row_out | output | 4096 | Current register contents, captured by the row on a register-to-row transfer |

## Verification
Transfer and serial results are due one system clock after their stimulus. The pointer, the stored entries, `sio_out` and the port mode all change at the edge that sees `xfer_valid` or a fresh `sc` high, because the edge detector and the action share that edge. `sio_oe` follows `se_n` combinationally. The bench therefore drives every input on the falling clock edge and checks on the next falling edge, after exactly one rising edge has acted. It checks `sio_out` both after the `sc` rise and after the `sc` fall, which confirms that the value holds between serial edges. Masked steps and dropped steps are checked through `row_out` and through where the next store or read lands.

// File: rtl/sam_pkg.sv
// Shared types for the serial access register port.
// Assumes nothing beyond the standard language.
package sam_pkg;
    // Direction of the serial pins, chosen by the last transfer.
    typedef enum logic {
        PORT_IN  = 1'b0,
        PORT_OUT = 1'b1
    } port_dir_e;
endpackage

// File: rtl/sam_edge.sv
// Detects a rising serial clock level in the system clock domain.
// Assumes sc is already synchronous to clk and stays high or low
// for at least one clk cycle per level.
module sam_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sc,
    output logic rise
);
    logic sc_q;

    // Remember the level seen at the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sc_q <= 1'b0;
        else        sc_q <= sc;
    end

    assign rise = sc & ~sc_q;
endmodule

// File: rtl/sam_pointer.sv
// Serial address pointer: a load takes priority over a step, and a
// step wraps from the last entry back to zero.
// Assumes load and step are single-cycle qualifiers.
module sam_pointer #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Load the start column, or advance with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr <= '0;
        else if (load)  ptr <= load_val;
        else if (step)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/sam_store.sv
// Register array of DEPTH entries of WIDTH bits. It has a whole-row
// parallel load, a single-entry serial write and a registered
// serial read. A row load outranks a serial write.
// Assumes wr_en and rd_en are never both needed for the same purpose
// in one cycle (the top picks one from the port mode).
module sam_store #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int ROWW  = DEPTH * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_load,
    input  logic [ROWW-1:0]  row_in,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    output logic [ROWW-1:0]  row_out
);
    logic [WIDTH-1:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Each entry takes a row load first, then a matching serial write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[g] <= '0;
            else if (row_load)
                ent[g] <= row_in[g*WIDTH +: WIDTH];
            else if (wr_en && (wr_addr == AW'(g)))
                ent[g] <= wr_data;
        end
        assign row_out[g*WIDTH +: WIDTH] = ent[g];
    end

    // Serial output register, updated only on a read step.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= ent[rd_addr];
    end
endmodule

// File: rtl/sam_port.sv
// Serial access register port of a video memory. A transfer strobe
// loads or unloads the whole row, sets the pointer start column and
// picks the serial direction. Serial clock rising edges then step
// the pointer, and each step reads or writes one entry. The
// active-low enable masks drive and stores but never the step.
// Assumes sc is synchronous to clk; split transfer and the RAM
// array itself live outside this block.
module sam_port #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int ROWW  = DEPTH * WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sc,
    input  logic             se_n,
    input  logic [WIDTH-1:0] sio_in,
    output logic [WIDTH-1:0] sio_out,
    output logic             sio_oe,
    input  logic             xfer_valid,
    input  logic             xfer_to_sam,
    input  logic [AW-1:0]    xfer_col,
    input  logic [ROWW-1:0]  row_in,
    output logic [ROWW-1:0]  row_out
);
    import sam_pkg::*;

    port_dir_e     dir;
    logic          sc_rise;
    logic          step;
    logic          wr_en;
    logic          rd_en;
    logic [AW-1:0] ptr;

    sam_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sc    (sc),
        .rise  (sc_rise)
    );

    // Port direction follows the most recent transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)          dir <= PORT_IN;
        else if (xfer_valid) dir <= xfer_to_sam ? PORT_OUT : PORT_IN;
    end

    // A transfer in the same cycle swallows the serial step.
    always_comb begin
        step  = sc_rise & ~xfer_valid;
        wr_en = step & (dir == PORT_IN) & ~se_n;
        rd_en = step & (dir == PORT_OUT);
    end

    sam_pointer #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (xfer_valid),
        .load_val (xfer_col),
        .step     (step),
        .ptr      (ptr)
    );

    sam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW), .ROWW(ROWW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_load (xfer_valid & xfer_to_sam),
        .row_in   (row_in),
        .wr_en    (wr_en),
        .wr_addr  (ptr),
        .wr_data  (sio_in),
        .rd_en    (rd_en),
        .rd_addr  (ptr),
        .rd_data  (sio_out),
        .row_out  (row_out)
    );

    assign sio_oe = (dir == PORT_OUT) & ~se_n;
endmodule

// File: rtl/sam_port_chk.sv
// Port-level properties of sam_port, attached by bind.
// Assumes the synchronous active-low reset of the host block.
module sam_port_chk #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int ROWW  = DEPTH * WIDTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sc,
    input logic             se_n,
    input logic [WIDTH-1:0] sio_out,
    input logic             sio_oe,
    input logic             xfer_valid,
    input logic             xfer_to_sam,
    input logic [ROWW-1:0]  row_in,
    input logic [ROWW-1:0]  row_out
);
    logic sc_seen;

    // Independent copy of the last sampled serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sc_seen <= 1'b0;
        else        sc_seen <= sc;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!sio_oe && sio_out == '0)); // R1
    AST_ROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_to_sam) |=> (row_out == $past(row_in))); // R2
    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(sc && !sc_seen) |=> $stable(sio_out)); // R4
    AST_OE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_to_sam && !se_n) |=> (sio_oe || se_n)); // R5
    AST_UNLOAD_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_to_sam) |=> (!sio_oe && $stable(row_out))); // R6
    AST_MASK_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (se_n && !xfer_valid) |=> $stable(row_out)); // R8
    AST_XFER_DROPS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |=> $stable(sio_out)); // R10
    AST_OUT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (sio_oe && !xfer_valid) |=> $stable(row_out)); // R11
endmodule

bind sam_port sam_port_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW), .ROWW(ROWW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sc          (sc),
    .se_n        (se_n),
    .sio_out     (sio_out),
    .sio_oe      (sio_oe),
    .xfer_valid  (xfer_valid),
    .xfer_to_sam (xfer_to_sam),
    .row_in      (row_in),
    .row_out     (row_out)
);

// File: tb/tb_sam_port.sv
module tb_sam_port;
    localparam int DEPTH = 512;
    localparam int WIDTH = 8;
    localparam int AW    = 9;
    localparam int ROWW  = DEPTH * WIDTH;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sc;
    logic             se_n;
    logic [WIDTH-1:0] sio_in;
    logic [WIDTH-1:0] sio_out;
    logic             sio_oe;
    logic             xfer_valid;
    logic             xfer_to_sam;
    logic [AW-1:0]    xfer_col;
    logic [ROWW-1:0]  row_in;
    logic [ROWW-1:0]  row_out;

    logic [WIDTH-1:0] model [DEPTH];
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sam_port dut (
        .clk(clk), .rst_n(rst_n), .sc(sc), .se_n(se_n), .sio_in(sio_in),
        .sio_out(sio_out), .sio_oe(sio_oe), .xfer_valid(xfer_valid),
        .xfer_to_sam(xfer_to_sam), .xfer_col(xfer_col),
        .row_in(row_in), .row_out(row_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic chk_row(input string req);
        int bad_at;
        bad_at = -1;
        n_chk++;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (row_out[i*WIDTH +: WIDTH] !== model[i]) bad_at = i;
        if (bad_at >= 0) begin
            n_bad++;
            $display("FAIL %s entry %0d act=%0h exp=%0h", req, bad_at,
                     row_out[bad_at*WIDTH +: WIDTH], model[bad_at]);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // One serial rise (sampled after it acts); fall is a separate task.
    task automatic sc_up();
        sc = 1'b1;
        tick();
    endtask

    task automatic sc_down();
        sc = 1'b0;
        tick();
    endtask

    task automatic fill_row(input logic [7:0] seed);
        for (int i = 0; i < DEPTH; i++) begin
            row_in[i*WIDTH +: WIDTH] = 8'((i * 13) + seed);
            model[i] = 8'((i * 13) + seed);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; sc = 1'b0; se_n = 1'b0; sio_in = '0;
        xfer_valid = 1'b0; xfer_to_sam = 1'b0; xfer_col = '0; row_in = '0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) tick();
        chk("R1 oe in reset", 32'(sio_oe), 0);
        chk("R1 sio_out in reset", 32'(sio_out), 0);
        chk_row("R1 entries in reset");
        rst_n = 1'b1;
        tick();
        chk("R1 oe after reset", 32'(sio_oe), 0);
        chk("R1 sio_out after reset", 32'(sio_out), 0);
    endtask

    task automatic t_read(input int col, input logic [7:0] seed, input string tag);
        fill_row(seed);
        xfer_valid = 1'b1; xfer_to_sam = 1'b1; xfer_col = AW'(col);
        tick();
        xfer_valid = 1'b0;
        chk_row("R2 row load");
        chk("R5 oe with enable low", 32'(sio_oe), 1);
        se_n = 1'b1;
        tick();
        chk("R5 oe with enable high", 32'(sio_oe), 0);
        se_n = 1'b0;
        tick();
        for (int k = 0; k < 3; k++) begin
            sc_up();
            chk(tag, 32'(sio_out), 32'(model[(col + k) % DEPTH]));
            sc_down();
            chk("R4 hold between rises", 32'(sio_out), 32'(model[(col + k) % DEPTH]));
        end
        chk_row("R11 reads leave entries");
    endtask

    task automatic t_write();
        xfer_valid = 1'b1; xfer_to_sam = 1'b0; xfer_col = 9'd20;
        tick();
        xfer_valid = 1'b0;
        chk("R6 input mode oe", 32'(sio_oe), 0);
        chk_row("R6 unload keeps entries");
        sio_in = 8'hA1; sc_up(); sc_down();
        model[20] = 8'hA1;
        chk_row("R7 store at pointer");
        se_n = 1'b1; sio_in = 8'hB2; sc_up();
        chk("R6 oe stays low", 32'(sio_oe), 0);
        sc_down();
        chk_row("R8 masked step stores nothing");
        se_n = 1'b0; sio_in = 8'hC3; sc_up(); sc_down();
        model[22] = 8'hC3;
        chk_row("R8 pointer advanced past mask");
    endtask

    task automatic t_collide();
        logic [7:0] held;
        // Input mode, pointer now at 23: a transfer and a rise together.
        sio_in = 8'h5A; se_n = 1'b0;
        sc = 1'b1; xfer_valid = 1'b1; xfer_to_sam = 1'b0; xfer_col = 9'd40;
        tick();
        xfer_valid = 1'b0;
        sc_down();
        chk_row("R10 dropped step stores nothing");
        sio_in = 8'h77; sc_up(); sc_down();
        model[40] = 8'h77;
        chk_row("R10 pointer holds start column");
        // Output mode: transfer wins over a rise, sio_out unchanged.
        held = sio_out;
        fill_row(8'h05);
        sc = 1'b1; xfer_valid = 1'b1; xfer_to_sam = 1'b1; xfer_col = 9'd100;
        tick();
        xfer_valid = 1'b0;
        chk("R10 sio_out kept on collision", 32'(sio_out), 32'(held));
        sc_down();
        sc_up();
        chk("R10 first read at start column", 32'(sio_out), 32'(model[100]));
        sc_down();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_read(5, 8'h11, "R3 read sequence");
        t_read(510, 8'h40, "R9 pointer wrap");
        t_write();
        t_collide();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule